// File: doc/BRIEF.md
# Stochastic-Rounding Spike Trace Bank

This block holds one low-pass spike trace per source neuron, plus a small per-source spike counter. Each trace obeys x[t] = alpha*x[t-1] + delta*s[t], with s[t] either 0 or 1. Every source has its own decay factor alpha and its own impulse delta. The trace is stored as a 7-bit unsigned value.

The decay product alpha*x has a fractional part. That part is not truncated. It is resolved by stochastic rounding against a free-standing 16-bit pseudorandom generator. The generator seed can be written, so a run can be reproduced exactly.

An algorithmic time step is applied one source at a time. A strobe names the source index and carries its spike bit. The selected trace decays, then takes the impulse if the spike bit is set. This gives two uses:
- With delta at full scale, every spike drives the trace to its ceiling. The decay that follows then measures the time since the last spike.
- With a smaller delta, spikes that arrive close together pile up. The trace then follows the spike rate.

A combinational read port returns any source's trace and count.

Top module: `spike_trace_bank`

## Requirements
- R1: After reset every trace, every spike count and every alpha and delta is 0, and the generator state is 16'hACE1.
- R2: A configuration write (cfgWe=1) stores cfgAlpha (8 bits, decay factor cfgAlpha/256) and cfgDelta (7 bits) for entry cfgIdx. It changes no trace, no count and no other entry's settings.
- R3: A step (stepValid=1) on entry i replaces its trace x with floor(alpha*x/256). It adds 1 when the low 8 bits of the 15-bit product alpha*x are strictly greater than bits [7:0] of the current generator state.
- R4: When stepSpike=1 on a step, delta is added to the decayed value, and the sum saturates at 127.
- R5: The generator state s advances to {s[14:0], s[15]^s[14]^s[12]^s[3]} exactly once per step and at no other time. A seed write (seedWe=1) loads seed instead, and a zero seed loads 16'h0001.
- R6: With delta=127, a spike step leaves the trace at 127 whatever its prior value, and later spike-free steps follow the decay of R3 from 127.
- R7: With delta below 127, spikes on consecutive steps accumulate according to R3 and R4.
- R8: A spike step increments the entry's 5-bit count, which holds at 31 instead of wrapping.
- R9: epochClr=1 clears every count. A spike step in the same cycle leaves its entry's count at 1. Traces are unaffected.
- R10: The trace of an entry that is not the target of a step is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepValid | input | 1 | Apply one time step to entry stepIdx |
| stepIdx | input | IDX_W | Entry to step |
| stepSpike | input | 1 | Spike bit of the stepped entry |
| epochClr | input | 1 | Clear all spike counts (start of epoch) |
| cfgWe | input | 1 | Write alpha and delta of entry cfgIdx |
| cfgIdx | input | IDX_W | Entry to configure |
| cfgAlpha | input | ALPHA_W | Decay factor, fraction of 256 |
| cfgDelta | input | TRACE_W | Impulse amount |
| seedWe | input | 1 | Load the generator state |
| seed | input | 16 | Generator seed |
| rdIdx | input | IDX_W | Entry to read |
| rdTrace | output | TRACE_W | Trace of entry rdIdx |
| rdCount | output | CNT_W | Spike count of entry rdIdx |

## Verification
The properties assume that:
- stepIdx and rdIdx stay below the number of entries;
- a reading is only compared across cycles in which rdIdx is held.

The bench always drives valid indices. It changes inputs only on the falling clock edge, and it holds rdIdx across every strobe it issues. Under these conditions, the no-rise-on-decay check, the untouched-entry check and the counter checks have defined meaning. The bench never writes a seed in the same cycle as a step, so the generator state that each step uses is unambiguous for its own model.

// File: rtl/spike_trace_pkg.sv
package spike_trace_pkg;
  localparam int LFSR_W = 16;

  typedef struct packed {
    logic stepEn;
    logic addImpulse;
    logic epochClr;
    logic cfgEn;
    logic seedEn;
  } trace_strobes_t;
endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import spike_trace_pkg::*;
(
  input  logic           stepValid,
  input  logic           stepSpike,
  input  logic           epochClr,
  input  logic           cfgWe,
  input  logic           seedWe,
  output trace_strobes_t strobes
);
  always_comb begin
    strobes.stepEn     = stepValid;
    strobes.addImpulse = stepValid & stepSpike;
    strobes.epochClr   = epochClr;
    strobes.cfgEn      = cfgWe;
    strobes.seedEn     = seedWe;
  end
endmodule

// File: rtl/trace_lfsr.sv
module trace_lfsr
  import spike_trace_pkg::*;
#(
  parameter logic [LFSR_W-1:0] RESET_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  output logic [LFSR_W-1:0] state
);
  logic feedback;
  assign feedback = state[15] ^ state[14] ^ state[12] ^ state[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= RESET_SEED;
    else if (load)    state <= (seed == '0) ? LFSR_W'(1) : seed;
    else if (advance) state <= {state[LFSR_W-2:0], feedback};
  end
endmodule

// File: rtl/trace_dp.sv
module trace_dp
  import spike_trace_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int TRACE_W = 7,
  parameter int ALPHA_W = 8,
  parameter int CNT_W   = 5,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  trace_strobes_t     strobes,
  input  logic [IDX_W-1:0]   stepIdx,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [ALPHA_W-1:0] cfgAlpha,
  input  logic [TRACE_W-1:0] cfgDelta,
  input  logic [ALPHA_W-1:0] rnd,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [TRACE_W-1:0] rdTrace,
  output logic [CNT_W-1:0]   rdCount
);
  localparam int PROD_W = ALPHA_W + TRACE_W;
  localparam logic [TRACE_W-1:0] TRACE_MAX = {TRACE_W{1'b1}};
  localparam logic [CNT_W-1:0]   CNT_MAX   = {CNT_W{1'b1}};

  logic [TRACE_W-1:0] traceArr [NUM_SRC];
  logic [CNT_W-1:0]   cntArr   [NUM_SRC];
  logic [ALPHA_W-1:0] alphaArr [NUM_SRC];
  logic [TRACE_W-1:0] deltaArr [NUM_SRC];

  // shared update arithmetic for the selected entry
  logic [PROD_W-1:0]  prod;
  logic [TRACE_W-1:0] decayed;
  logic [TRACE_W:0]   sum;
  logic [TRACE_W-1:0] nextTrace;
  logic               roundUp;

  always_comb begin
    prod      = PROD_W'(alphaArr[stepIdx]) * PROD_W'(traceArr[stepIdx]);
    roundUp   = prod[ALPHA_W-1:0] > rnd;
    decayed   = prod[PROD_W-1:ALPHA_W] + TRACE_W'(roundUp);
    sum       = {1'b0, decayed} +
                {1'b0, (strobes.addImpulse ? deltaArr[stepIdx] : '0)};
    nextTrace = sum[TRACE_W] ? TRACE_MAX : sum[TRACE_W-1:0];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
    logic [TRACE_W-1:0] trQ;
    logic [CNT_W-1:0]   cntQ;
    logic [ALPHA_W-1:0] alphaQ;
    logic [TRACE_W-1:0] deltaQ;
    logic               stepHit;

    assign stepHit = strobes.stepEn && (stepIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        trQ    <= '0;
        cntQ   <= '0;
        alphaQ <= '0;
        deltaQ <= '0;
      end else begin
        if (strobes.cfgEn && (cfgIdx == IDX_W'(g))) begin
          alphaQ <= cfgAlpha;
          deltaQ <= cfgDelta;
        end
        if (stepHit) trQ <= nextTrace;
        if (strobes.epochClr)
          cntQ <= (stepHit && strobes.addImpulse) ? CNT_W'(1) : '0;
        else if (stepHit && strobes.addImpulse && (cntQ != CNT_MAX))
          cntQ <= cntQ + CNT_W'(1);
      end
    end

    assign traceArr[g] = trQ;
    assign cntArr[g]   = cntQ;
    assign alphaArr[g] = alphaQ;
    assign deltaArr[g] = deltaQ;
  end

  assign rdTrace = traceArr[rdIdx];
  assign rdCount = cntArr[rdIdx];
endmodule

// File: rtl/spike_trace_bank.sv
module spike_trace_bank
  import spike_trace_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int TRACE_W = 7,
  parameter int ALPHA_W = 8,
  parameter int CNT_W   = 5,
  parameter logic [LFSR_W-1:0] RESET_SEED = 16'hACE1,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stepValid,
  input  logic [IDX_W-1:0]   stepIdx,
  input  logic               stepSpike,
  input  logic               epochClr,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [ALPHA_W-1:0] cfgAlpha,
  input  logic [TRACE_W-1:0] cfgDelta,
  input  logic               seedWe,
  input  logic [LFSR_W-1:0]  seed,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [TRACE_W-1:0] rdTrace,
  output logic [CNT_W-1:0]   rdCount
);
  trace_strobes_t    strobes;
  logic [LFSR_W-1:0] lfsrState;

  trace_ctrl u_ctrl (
    .stepValid (stepValid),
    .stepSpike (stepSpike),
    .epochClr  (epochClr),
    .cfgWe     (cfgWe),
    .seedWe    (seedWe),
    .strobes   (strobes)
  );

  trace_lfsr #(.RESET_SEED(RESET_SEED)) u_lfsr (
    .clk     (clk),
    .rstN    (rstN),
    .advance (strobes.stepEn),
    .load    (strobes.seedEn),
    .seed    (seed),
    .state   (lfsrState)
  );

  trace_dp #(
    .NUM_SRC (NUM_SRC),
    .TRACE_W (TRACE_W),
    .ALPHA_W (ALPHA_W),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .stepIdx  (stepIdx),
    .cfgIdx   (cfgIdx),
    .cfgAlpha (cfgAlpha),
    .cfgDelta (cfgDelta),
    .rnd      (lfsrState[ALPHA_W-1:0]),
    .rdIdx    (rdIdx),
    .rdTrace  (rdTrace),
    .rdCount  (rdCount)
  );
endmodule

// File: rtl/spike_trace_bank_chk.sv
module spike_trace_bank_chk #(
  parameter int NUM_SRC = 8,
  parameter int TRACE_W = 7,
  parameter int CNT_W   = 5,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic               stepValid,
  input logic [IDX_W-1:0]   stepIdx,
  input logic               stepSpike,
  input logic               epochClr,
  input logic [IDX_W-1:0]   rdIdx,
  input logic [TRACE_W-1:0] rdTrace,
  input logic [CNT_W-1:0]   rdCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_HOLD_UNSTEPPED: assert property (@(posedge clk) disable iff (!rstN)
    !(stepValid && stepIdx == rdIdx) |=> (!$stable(rdIdx) || $stable(rdTrace))); // R10

  AST_DECAY_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && !stepSpike && stepIdx == rdIdx)
      |=> (!$stable(rdIdx) || rdTrace <= $past(rdTrace))); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && stepSpike && stepIdx == rdIdx && !epochClr)
      |=> (!$stable(rdIdx) ||
           rdCount == (($past(rdCount) == CNT_MAX) ? CNT_MAX
                                                   : CNT_W'($past(rdCount) + CNT_W'(1))))); // R8

  AST_EPOCH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (epochClr && !(stepValid && stepSpike)) |=> rdCount == '0); // R9
endmodule

bind spike_trace_bank spike_trace_bank_chk #(
  .NUM_SRC (NUM_SRC),
  .TRACE_W (TRACE_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stepValid (stepValid),
  .stepIdx   (stepIdx),
  .stepSpike (stepSpike),
  .epochClr  (epochClr),
  .rdIdx     (rdIdx),
  .rdTrace   (rdTrace),
  .rdCount   (rdCount)
);

// File: tb/sim_spike_trace_bank.sv
module sim_spike_trace_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stepValid = 1'b0;
  logic [2:0] stepIdx = '0;
  logic       stepSpike = 1'b0;
  logic       epochClr = 1'b0;
  logic       cfgWe = 1'b0;
  logic [2:0] cfgIdx = '0;
  logic [7:0] cfgAlpha = '0;
  logic [6:0] cfgDelta = '0;
  logic       seedWe = 1'b0;
  logic [15:0] seed = '0;
  logic [2:0] rdIdx = '0;
  logic [6:0] rdTrace;
  logic [4:0] rdCount;

  int total = 0;
  int bad = 0;

  int mTrace [N];
  int mCnt   [N];
  int mAlpha [N];
  int mDelta [N];
  logic [15:0] mLfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  spike_trace_bank u0 (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .stepIdx(stepIdx),
    .stepSpike(stepSpike), .epochClr(epochClr), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgAlpha(cfgAlpha), .cfgDelta(cfgDelta), .seedWe(seedWe), .seed(seed),
    .rdIdx(rdIdx), .rdTrace(rdTrace), .rdCount(rdCount)
  );

  function automatic int modelStep(int x, int a, int d, int spk, int r);
    int p, v;
    p = a * x;
    v = (p >> 8) + (((p & 255) > r) ? 1 : 0);
    if (spk != 0) v = v + d;
    if (v > 127) v = 127;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkEntry(string req, int idx);
    rdIdx = 3'(idx);
    #1;
    check(req, int'(rdTrace), mTrace[idx]);
    check(req, int'(rdCount), mCnt[idx]);
  endtask

  task automatic checkAll(string req);
    for (int i = 0; i < N; i++) checkEntry(req, i);
  endtask

  task automatic cfgWrite(int idx, int a, int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 3'(idx); cfgAlpha = 8'(a); cfgDelta = 7'(d);
    @(negedge clk);
    cfgWe = 1'b0;
    mAlpha[idx] = a; mDelta[idx] = d;
  endtask

  task automatic loadSeed(logic [15:0] s);
    @(negedge clk);
    seedWe = 1'b1; seed = s;
    @(negedge clk);
    seedWe = 1'b0;
    mLfsr = (s == 16'h0) ? 16'h0001 : s;
  endtask

  task automatic doStep(int idx, int spk, int clr);
    @(negedge clk);
    stepValid = 1'b1; stepIdx = 3'(idx); stepSpike = (spk != 0); epochClr = (clr != 0);
    mTrace[idx] = modelStep(mTrace[idx], mAlpha[idx], mDelta[idx], spk, int'(mLfsr[7:0]));
    mLfsr = {mLfsr[14:0], mLfsr[15] ^ mLfsr[14] ^ mLfsr[12] ^ mLfsr[3]};
    if (clr != 0) begin
      for (int i = 0; i < N; i++) mCnt[i] = 0;
      if (spk != 0) mCnt[idx] = 1;
    end else if (spk != 0 && mCnt[idx] < 31) mCnt[idx]++;
    @(negedge clk);
    stepValid = 1'b0; stepSpike = 1'b0; epochClr = 1'b0;
  endtask

  task automatic epochOnly();
    @(negedge clk);
    epochClr = 1'b1;
    @(negedge clk);
    epochClr = 1'b0;
    for (int i = 0; i < N; i++) mCnt[i] = 0;
  endtask

  task automatic testReset();
    checkAll("R1");
    doStep(0, 1, 0);            // alpha=0, delta=0 after reset
    checkEntry("R1", 0);
    check("R1", int'(rdTrace), 0);
  endtask

  task automatic testConfig();
    doStep(1, 0, 0);
    cfgWrite(1, 77, 33);
    checkAll("R2");
    doStep(1, 1, 0);            // uses stored delta
    checkEntry("R2", 1);
    check("R2", int'(rdTrace), 33);
  endtask

  task automatic testFullScale();
    cfgWrite(2, 200, 127);
    doStep(2, 1, 0);
    checkEntry("R6", 2);
    check("R6", int'(rdTrace), 127);
    for (int k = 0; k < 6; k++) begin
      doStep(2, 0, 0);
      checkEntry("R3", 2);
    end
    doStep(2, 1, 0);
    check("R6", int'(rdTrace), 127);
    checkEntry("R6", 2);
  endtask

  task automatic testRate();
    cfgWrite(3, 230, 20);
    for (int k = 0; k < 4; k++) begin
      doStep(3, 1, 0);
      checkEntry("R7", 3);
    end
    for (int k = 0; k < 8; k++) begin
      doStep(3, (k % 3 == 0) ? 1 : 0, 0);
      checkEntry("R7", 3);
    end
  endtask

  task automatic testSaturate();
    cfgWrite(5, 255, 100);
    doStep(5, 1, 0);
    doStep(5, 1, 0);
    checkEntry("R4", 5);
    check("R4", int'(rdTrace), 127);
    checkAll("R10");
  endtask

  task automatic testRounding();
    cfgWrite(6, 129, 100);
    doStep(6, 1, 0);            // trace 100
    loadSeed(16'h0080);         // rnd 128, fraction 100 not greater
    doStep(6, 0, 0);
    checkEntry("R5", 6);
    check("R5", int'(rdTrace), 50);
    cfgWrite(7, 129, 100);
    doStep(7, 1, 0);
    loadSeed(16'h0010);         // rnd 16, fraction 100 greater
    doStep(7, 0, 0);
    checkEntry("R5", 7);
    check("R5", int'(rdTrace), 51);
    loadSeed(16'h0000);         // forced to 1
    for (int k = 0; k < 10; k++) begin
      doStep(6, k % 2, 0);
      checkEntry("R5", 6);
    end
  endtask

  task automatic testCounter();
    for (int k = 0; k < 35; k++) doStep(4, 1, 0);
    checkEntry("R8", 4);
    check("R8", int'(rdCount), 31);
  endtask

  task automatic testEpoch();
    epochOnly();
    checkAll("R9");
    doStep(4, 1, 0);
    doStep(4, 1, 1);            // clear together with a spike
    checkEntry("R9", 4);
    check("R9", int'(rdCount), 1);
    checkAll("R9");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      mTrace[i] = 0; mCnt[i] = 0; mAlpha[i] = 0; mDelta[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testConfig();
    testFullScale();
    testRate();
    testSaturate();
    testRounding();
    testCounter();
    testEpoch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule